// File: doc/BRIEF.md
# Normalising barrel shifter with shift-amount control

This block shifts a 16-bit word by 0 to 15 places in one of three styles: logical (vacated bits become zero), arithmetic right (vacated bits copy the original sign bit) or rotate (bits leaving one end re-enter at the other). A 4-bit opcode chooses the style, the direction and where the shift amount comes from. The amount can come from a captured external shift value, from one of two programmable 4-bit amount registers, or from a priority encoder. In that last case the encoder normalises the word as a two's-complement value.

The opcode and the shift value are captured on a rising clock edge and act during the following cycle. The data input is read during that execute cycle, and the shifted word is registered at its end. Normalise opcodes report the count they found on a shift-value port whose direction depends on the opcode. Two of them also store that count in an amount register, so a later shift can reuse it. A strap input can force the port to input only. A synchronous clear zeroes both amount registers and the output register.

Top module: `norm_shifter`

## Requirements
- R1: After reset, and on the clock edge where `clear` is high, `data_out` becomes 0 and both amount registers become 0. A later shift by either register then passes the data through unchanged.
- R2: Opcode 0 shifts `data_in` logically right by the captured shift value, and opcode 1 shifts it logically left. Vacated bits are zero.
- R3: Opcode 2 rotates right by the captured shift value and opcode 3 rotates left. Bits that leave one end re-enter at the other.
- R4: Opcodes A, B and C shift arithmetically right, filling with bit 15 of `data_in`. The amount comes from the captured shift value, amount register 1 and amount register 2 respectively.
- R5: Opcodes 4 and 5 shift logically right and left by amount register 1. Opcodes 6 and 7 do the same by amount register 2.
- R6: Opcode 8 loads amount register 1 from the captured shift value, and opcode 9 loads amount register 2. During either, `data_out` takes `data_in` unshifted.
- R7: Opcode D computes a count: the number of left shifts needed until bit 15 differs from bit 14, or 15 when the input is all zeros or all ones. `data_out` takes `data_in` shifted left by that count with zero fill. `sv_out` carries the count during the execute cycle.
- R8: Opcodes E and F behave like D, and also store the count in amount register 1 (E) or amount register 2 (F).
- R9: `sv_oe` is 1 exactly when the executing opcode is D, E or F and `sv_in_only` is 0. It is 0 for every other opcode.
- R10: `op_in` and `sv_in` are sampled on one rising edge. `data_in` is sampled on the next rising edge, and the result appears on `data_out` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of amount registers and output |
| op_in | input | 4 | Shifter opcode, captured each edge |
| sv_in | input | 4 | Shift-value port, input side |
| sv_out | output | 4 | Shift-value port, output side (normalise count) |
| sv_oe | output | 1 | Drive enable for the shift-value port |
| sv_in_only | input | 1 | Strap forcing the shift-value port to input only |
| data_in | input | 16 | Word to shift, read in the execute cycle |
| data_out | output | 16 | Registered shifted word |

## Verification
A corrupted amount register stays hidden until a later opcode shifts by that register. It then shows on `data_out` as a wrong shift distance one edge after that opcode executes. For this reason every register-sourced shift is run right after a load of a known amount, and again after a normalise that stores its count. A wrongly captured opcode shows in the execute cycle itself, as a wrong `sv_oe` level, before the data result is registered. Wrong encoder output shows both on `sv_out` in that cycle and on `data_out` one edge later.

// File: rtl/nsh_pkg.sv
`timescale 1ns/1ps
package nsh_pkg;

    typedef enum logic [3:0] {
        OP_LSR_SV  = 4'h0,
        OP_LSL_SV  = 4'h1,
        OP_ROR_SV  = 4'h2,
        OP_ROL_SV  = 4'h3,
        OP_LSR_A1  = 4'h4,
        OP_LSL_A1  = 4'h5,
        OP_LSR_A2  = 4'h6,
        OP_LSL_A2  = 4'h7,
        OP_LD_A1   = 4'h8,
        OP_LD_A2   = 4'h9,
        OP_ASR_SV  = 4'hA,
        OP_ASR_A1  = 4'hB,
        OP_ASR_A2  = 4'hC,
        OP_NORM    = 4'hD,
        OP_NORM_A1 = 4'hE,
        OP_NORM_A2 = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        SK_PASS,
        SK_LSR,
        SK_LSL,
        SK_ROR,
        SK_ROL,
        SK_ASR
    } shk_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_SV,
        SRC_A1,
        SRC_A2,
        SRC_PE
    } src_e;

endpackage

// File: rtl/nsh_decode.sv
`timescale 1ns/1ps
module nsh_decode
    import nsh_pkg::*;
(
    input  logic [3:0] op,
    output shk_e       kind,
    output src_e       src,
    output logic       ld_a1,
    output logic       ld_a2,
    output logic       drive_sv
);
    always_comb begin
        kind     = SK_PASS;
        src      = SRC_NONE;
        ld_a1    = 1'b0;
        ld_a2    = 1'b0;
        drive_sv = 1'b0;
        unique case (op_e'(op))
            OP_LSR_SV:  begin kind = SK_LSR; src = SRC_SV; end
            OP_LSL_SV:  begin kind = SK_LSL; src = SRC_SV; end
            OP_ROR_SV:  begin kind = SK_ROR; src = SRC_SV; end
            OP_ROL_SV:  begin kind = SK_ROL; src = SRC_SV; end
            OP_LSR_A1:  begin kind = SK_LSR; src = SRC_A1; end
            OP_LSL_A1:  begin kind = SK_LSL; src = SRC_A1; end
            OP_LSR_A2:  begin kind = SK_LSR; src = SRC_A2; end
            OP_LSL_A2:  begin kind = SK_LSL; src = SRC_A2; end
            OP_LD_A1:   begin kind = SK_PASS; ld_a1 = 1'b1; end
            OP_LD_A2:   begin kind = SK_PASS; ld_a2 = 1'b1; end
            OP_ASR_SV:  begin kind = SK_ASR; src = SRC_SV; end
            OP_ASR_A1:  begin kind = SK_ASR; src = SRC_A1; end
            OP_ASR_A2:  begin kind = SK_ASR; src = SRC_A2; end
            OP_NORM:    begin kind = SK_LSL; src = SRC_PE; drive_sv = 1'b1; end
            OP_NORM_A1: begin kind = SK_LSL; src = SRC_PE; drive_sv = 1'b1; ld_a1 = 1'b1; end
            OP_NORM_A2: begin kind = SK_LSL; src = SRC_PE; drive_sv = 1'b1; ld_a2 = 1'b1; end
            default:    begin kind = SK_PASS; end
        endcase
    end
endmodule

// File: rtl/nsh_prienc.sv
`timescale 1ns/1ps
module nsh_prienc #(
    parameter int W  = 16,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    output logic [AW-1:0] count
);
    // edge[j] marks a sign change between bit j and bit j-1
    logic [W-1:1] edge_bits;

    for (genvar j = 1; j < W; j++) begin : g_edge
        assign edge_bits[j] = data[j] ^ data[j-1];
    end

    always_comb begin
        count = AW'(W - 1);
        for (int j = 1; j < W; j++) begin
            if (edge_bits[j]) count = AW'(W - 1 - j);
        end
    end
endmodule

// File: rtl/nsh_barrel.sv
`timescale 1ns/1ps
module nsh_barrel
    import nsh_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  data,
    input  logic [AW-1:0] amt,
    input  shk_e          kind,
    output logic [W-1:0]  result
);
    logic          go_left;
    logic          rotate;
    logic          fill;
    logic [W-1:0]  src_word;
    logic [AW:0][W-1:0] stg;

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    assign go_left  = (kind == SK_LSL) || (kind == SK_ROL);
    assign rotate   = (kind == SK_ROR) || (kind == SK_ROL);
    assign fill     = (kind == SK_ASR) ? data[W-1] : 1'b0;
    assign src_word = go_left ? flip(data) : data;
    assign stg[0]   = src_word;

    // right-shift network; left shifts run on the bit-reversed word
    for (genvar s = 0; s < AW; s++) begin : g_stage
        for (genvar b = 0; b < W; b++) begin : g_bit
            localparam int FROM = b + (1 << s);
            if (FROM < W) begin : g_in
                assign stg[s+1][b] = amt[s] ? stg[s][FROM] : stg[s][b];
            end else begin : g_wrap
                assign stg[s+1][b] = amt[s] ? (rotate ? stg[s][FROM-W] : fill)
                                            : stg[s][b];
            end
        end
    end

    always_comb begin
        if (kind == SK_PASS) result = data;
        else if (go_left)    result = flip(stg[AW]);
        else                 result = stg[AW];
    end
endmodule

// File: rtl/norm_shifter.sv
`timescale 1ns/1ps
module norm_shifter
    import nsh_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [3:0]    op_in,
    input  logic [AW-1:0] sv_in,
    output logic [AW-1:0] sv_out,
    output logic          sv_oe,
    input  logic          sv_in_only,
    input  logic [W-1:0]  data_in,
    output logic [W-1:0]  data_out
);
    logic [3:0]    op_q;
    logic [AW-1:0] sv_q;
    logic [AW-1:0] r1_q;
    logic [AW-1:0] r2_q;
    logic [AW-1:0] pe_cnt;
    logic [AW-1:0] amt;
    logic [AW-1:0] load_val;
    logic [W-1:0]  shifted;
    shk_e          kind;
    src_e          src;
    logic          ld_a1;
    logic          ld_a2;
    logic          drive_sv;

    // capture stage: opcode and shift value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0;
            sv_q <= '0;
        end else begin
            op_q <= op_in;
            sv_q <= sv_in;
        end
    end

    nsh_decode u_dec (
        .op       (op_q),
        .kind     (kind),
        .src      (src),
        .ld_a1    (ld_a1),
        .ld_a2    (ld_a2),
        .drive_sv (drive_sv)
    );

    nsh_prienc #(.W(W), .AW(AW)) u_pe (
        .data  (data_in),
        .count (pe_cnt)
    );

    always_comb begin
        unique case (src)
            SRC_SV:  amt = sv_q;
            SRC_A1:  amt = r1_q;
            SRC_A2:  amt = r2_q;
            SRC_PE:  amt = pe_cnt;
            default: amt = '0;
        endcase
    end

    assign load_val = (src == SRC_PE) ? pe_cnt : sv_q;

    nsh_barrel #(.W(W), .AW(AW)) u_bs (
        .data   (data_in),
        .amt    (amt),
        .kind   (kind),
        .result (shifted)
    );

    // execute stage: result and amount registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out <= '0;
            r1_q     <= '0;
            r2_q     <= '0;
        end else if (clear) begin
            data_out <= '0;
            r1_q     <= '0;
            r2_q     <= '0;
        end else begin
            data_out <= shifted;
            if (ld_a1) r1_q <= load_val;
            if (ld_a2) r2_q <= load_val;
        end
    end

    assign sv_out = pe_cnt;
    assign sv_oe  = drive_sv && !sv_in_only;
endmodule

// File: rtl/norm_shifter_chk.sv
`timescale 1ns/1ps
module norm_shifter_chk #(
    parameter int W  = 16,
    parameter int AW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic [3:0]    op_in,
    input logic          sv_in_only,
    input logic          sv_oe,
    input logic [AW-1:0] sv_out,
    input logic [W-1:0]  data_in,
    input logic [W-1:0]  data_out,
    input logic [3:0]    op_q,
    input logic [AW-1:0] r1_q,
    input logic [AW-1:0] r2_q
);
    // R1: clear empties output and amount registers
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (data_out == '0) && (r1_q == '0) && (r2_q == '0));

    // R9: drive only for a normalise opcode captured one edge earlier
    a_r9_oe_normalise: assert property (@(posedge clk) disable iff (!rst_n)
        sv_oe |-> ($past(op_in) >= 4'hD) && !sv_in_only);

    // R9: strap wins
    a_r9_strap: assert property (@(posedge clk) disable iff (!rst_n)
        sv_in_only |-> !sv_oe);

    // R6: load opcodes pass the data unshifted
    a_r6_load_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_q == 4'h8) || (op_q == 4'h9)) && !clear |=> data_out == $past(data_in));

    // R7: normalised result has a sign change at the top or is zero
    a_r7_norm_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == 4'hD) && !clear |=> (data_out == '0) || (data_out[W-1] != data_out[W-2]));

    // R8: stored count equals the count presented on the port
    a_r8_store_a1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == 4'hE) && !clear |=> r1_q == $past(sv_out));
    a_r8_store_a2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == 4'hF) && !clear |=> r2_q == $past(sv_out));
endmodule

bind norm_shifter norm_shifter_chk #(.W(W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .op_in      (op_in),
    .sv_in_only (sv_in_only),
    .sv_oe      (sv_oe),
    .sv_out     (sv_out),
    .data_in    (data_in),
    .data_out   (data_out),
    .op_q       (op_q),
    .r1_q       (r1_q),
    .r2_q       (r2_q)
);

// File: tb/tb_norm_shifter.sv
`timescale 1ns/1ps
module tb_norm_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic [3:0]  op_in = 4'h0;
    logic [3:0]  sv_in = 4'h0;
    logic [3:0]  sv_out;
    logic        sv_oe;
    logic        sv_in_only = 1'b0;
    logic [15:0] data_in = 16'h0;
    logic [15:0] data_out;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_r1 = 4'h0;
    logic [3:0] m_r2 = 4'h0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    norm_shifter dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .op_in(op_in), .sv_in(sv_in),
        .sv_out(sv_out), .sv_oe(sv_oe), .sv_in_only(sv_in_only),
        .data_in(data_in), .data_out(data_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] norm_count(input logic [15:0] d);
        for (int k = 0; k < 15; k++) begin
            logic [15:0] t;
            t = d << k;
            if (t[15] != t[14]) return 4'(k);
        end
        return 4'd15;
    endfunction

    function automatic logic [15:0] ref_result(input logic [3:0] op, input logic [3:0] a,
                                               input logic [15:0] d);
        logic [31:0] dd;
        dd = {d, d};
        case (op)
            4'h0, 4'h4, 4'h6: return d >> a;
            4'h1, 4'h5, 4'h7, 4'hD, 4'hE, 4'hF: return d << a;
            4'h2: return 16'(dd >> a);
            4'h3: return 16'((dd << a) >> 16);
            4'hA, 4'hB, 4'hC: return 16'($signed(d) >>> a);
            default: return d;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h0, 4'h1: return "R2";
            4'h2, 4'h3: return "R3";
            4'hA, 4'hB, 4'hC: return "R4";
            4'h4, 4'h5, 4'h6, 4'h7: return "R5";
            4'h8, 4'h9: return "R6";
            4'hD: return "R7";
            default: return "R8";
        endcase
    endfunction

    // one opcode: capture on edge 1, execute, result after edge 2 (R10)
    task automatic do_op(input logic [3:0] op, input logic [3:0] sv, input logic [15:0] d);
        logic [3:0] a;
        logic [15:0] exp;
        @(negedge clk);
        op_in = op; sv_in = sv; data_in = ~d;
        @(negedge clk);
        op_in = 4'h0; sv_in = 4'h0; data_in = d;
        case (op)
            4'h0, 4'h1, 4'h2, 4'h3, 4'hA: a = sv;
            4'h4, 4'h5, 4'hB: a = m_r1;
            4'h6, 4'h7, 4'hC: a = m_r2;
            4'hD, 4'hE, 4'hF: a = norm_count(d);
            default: a = 4'h0;
        endcase
        exp = ref_result(op, a, d);
        #1;
        check("R9 sv_oe", {31'd0, sv_oe}, {31'd0, (op >= 4'hD) && !sv_in_only});
        if (op >= 4'hD) check("R7 sv_out count", {28'd0, sv_out}, {28'd0, a});
        @(posedge clk); #1;
        check(req_of(op), {16'd0, data_out}, {16'd0, exp});
        if (op == 4'h8) m_r1 = sv;
        if (op == 4'h9) m_r2 = sv;
        if (op == 4'hE) m_r1 = a;
        if (op == 4'hF) m_r2 = a;
    endtask

    function automatic logic [15:0] pattern(input int i, input logic [15:0] rnd);
        case (i)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h0001;
            4: return 16'h4000;
            default: return rnd;
        endcase
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset data_out", {16'd0, data_out}, 32'd0);
        rst_n = 1'b1;
        // R1: registers hold zero after reset
        do_op(4'h4, 4'h0, 16'hBEEF);
        do_op(4'h6, 4'h0, 16'h1234);

        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int p = 0; p < 7; p++) begin
                    logic [15:0] d;
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    d = pattern(p, lfsr);
                    if (op == 4 || op == 5 || op == 11) do_op(4'h8, 4'(a), ~d);
                    if (op == 6 || op == 7 || op == 12) do_op(4'h9, 4'(a), ~d);
                    do_op(4'(op), 4'(a), d);
                end
            end
        end

        // R8: stored normalise count drives a following register shift
        do_op(4'hE, 4'h0, 16'h0003);
        do_op(4'h5, 4'h0, 16'h0003);
        do_op(4'hF, 4'h0, 16'hFFF8);
        do_op(4'h7, 4'h0, 16'h0005);

        // R9: strap forces input only for every opcode
        sv_in_only = 1'b1;
        for (int op = 0; op < 16; op++) do_op(4'(op), 4'h3, 16'h0F0F);
        sv_in_only = 1'b0;

        // R1: clear zeroes output and registers
        do_op(4'h8, 4'h7, 16'h1111);
        do_op(4'h9, 4'h5, 16'h2222);
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        check("R1 clear data_out", {16'd0, data_out}, 32'd0);
        m_r1 = 4'h0; m_r2 = 4'h0;
        do_op(4'h4, 4'h0, 16'hA5A5);
        do_op(4'hC, 4'h0, 16'h9000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule